// File: doc/BRIEF.md
# Critical-Conduction PFC Switch Controller

This block produces the gate command for the switch of a boost power-factor-correction stage that runs in critical-conduction mode. Each switching cycle has two parts. The switch is on for a commanded number of clock cycles. It then stays off until the inductor current has fallen to zero, which the block sees as a rising and then a falling edge on a zero-crossing comparator flag. If that falling edge never arrives, a watchdog interval forces the next turn-on.

Two protection paths act on the cycle. An over-current flag cuts the present on-time short, but only once a short leading-edge blanking window has passed. A bus over-voltage flag holds the gate low, and when the flag releases it forces one fresh turn-on. A global enable covers fault, dimming and undervoltage conditions and holds the gate low while it is low. When the enable returns, a forced turn-on starts switching again.

The on-time command is a digital stand-in for the error-amplifier output. The three comparator flags arrive asynchronously and each passes through a two-flop synchroniser. The enable is taken as already synchronous to the clock.

Top module: `pfc_crm_ctrl`

## Requirements
- R1: A turn-on drives `gate_o` high for exactly `ton_i` clock cycles. `ton_i` is sampled on the turn-on edge, so a change during the pulse does not alter that pulse.
- R2: If `ton_i` is zero when a turn-on is due, no pulse is produced. The watchdog interval restarts, and the gate stays low until a later turn-on finds a nonzero value.
- R3: After a turn-off, a falling edge on `zcd_i` turns the switch on again if `zcd_i` has risen since the last turn-on. `gate_o` goes high on the third clock edge after `zcd_i` falls.
- R4: A falling edge on `zcd_i` with no rising edge since the last turn-on is ignored.
- R5: If no valid zero-crossing turn-on occurs, `gate_o` rises exactly `WDOG_CYC` cycles after it fell.
- R6: `ocp_i` has no effect during the first `BLANK_CYC` cycles of an on-time. If it is held high through a pulse whose `ton_i` is larger, the pulse lasts exactly `BLANK_CYC` cycles.
- R7: If `ocp_i` rises after the blanking window, `gate_o` falls on the third clock edge after the rise. The next turn-on then waits for a zero-crossing or the watchdog.
- R8: `gate_o` is low from the third clock edge after `ovp_i` rises, and stays low for as long as `ovp_i` is high. When `ovp_i` falls, `gate_o` rises on the third clock edge after the fall.
- R9: While `rst_ni` is low, `gate_o` is low. If `en_i` is low at a clock edge, `gate_o` is low after that edge.
- R10: On the first clock edge at which `en_i` is sampled high, the block issues a forced turn-on and `gate_o` goes high, with no zero-crossing needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, 50 MHz nominal |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low means fault, dim or undervoltage |
| ton_i | input | ON_W | Commanded on-time in clock cycles; zero means no pulse |
| zcd_i | input | 1 | Inductor zero-crossing comparator flag (asynchronous) |
| ocp_i | input | 1 | Switch over-current comparator flag (asynchronous) |
| ovp_i | input | 1 | Bus over-voltage comparator flag with hysteresis (asynchronous) |
| gate_o | output | 1 | Registered gate command for the PFC switch |

## Verification
The three comparator flags reach the control logic through two synchroniser flops, and the decision is registered on the next edge. A change on `zcd_i`, `ocp_i` or `ovp_i` that is driven at a falling clock edge therefore appears on `gate_o` after the third rising edge. The bench samples one falling edge before that point, expecting the old value, and one falling edge after it, expecting the new value.

`en_i` is not synchronised, so its effect appears after the first rising edge. Pulse widths and off-times are counted in falling-edge samples of `gate_o`. Each requirement fixes the exact count expected: `ton_i`, `BLANK_CYC`, `WDOG_CYC`, or the action cycle plus two for a flag that arrives mid-pulse.

// File: rtl/pfc_crm_pkg.sv
package pfc_crm_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_ON   = 2'd1,
    PS_OFF  = 2'd2,
    PS_OVH  = 2'd3
  } pfc_state_e;

  localparam int unsigned FLAG_N   = 3;
  localparam int unsigned FLAG_ZCD = 0;
  localparam int unsigned FLAG_OCP = 1;
  localparam int unsigned FLAG_OVP = 2;

endpackage

// File: rtl/pfc_sync2.sv
module pfc_sync2 #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q;
    logic stab_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d_i[g];
        stab_q <= meta_q;
      end
    end

    assign q_o[g] = stab_q;
  end

endmodule

// File: rtl/pfc_edge.sv
module pfc_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;

endmodule

// File: rtl/pfc_interval.sv
module pfc_interval #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic cnt_en_i,
  output logic done_o
);

  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_we;

  always_comb begin
    cnt_we = clr_i | (cnt_en_i & (cnt_q != LAST));
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == LAST);

endmodule

// File: rtl/pfc_crm_fsm.sv
module pfc_crm_fsm
  import pfc_crm_pkg::*;
#(
  parameter int unsigned ON_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [ON_W-1:0] ton_i,
  input  logic            ovp_s_i,
  input  logic            ocp_s_i,
  input  logic            zcd_rise_i,
  input  logic            zcd_fall_i,
  input  logic            blank_done_i,
  input  logic            wd_done_i,
  output logic            fire_o,
  output logic            off_o,
  output pfc_state_e      state_o,
  output logic            gate_o
);

  localparam logic [ON_W-1:0] ONE = ON_W'(1);

  pfc_state_e      state_q, state_d;
  logic [ON_W-1:0] cnt_q, cnt_d;
  logic            armed_q, armed_d;
  logic            gate_q, gate_d;
  logic            fire, go_off, cnt_we;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    armed_d = armed_q | zcd_rise_i;
    fire    = 1'b0;
    go_off  = 1'b0;

    if (!en_i) begin
      state_d = PS_IDLE;
      armed_d = 1'b0;
    end else if (ovp_s_i) begin
      state_d = PS_OVH;
    end else begin
      unique case (state_q)
        PS_IDLE, PS_OVH: fire = 1'b1;
        PS_ON: begin
          if ((ocp_s_i && blank_done_i) || (cnt_q == ONE)) go_off = 1'b1;
          else                                            cnt_d  = cnt_q - ONE;
        end
        PS_OFF: begin
          if ((zcd_fall_i && armed_q) || wd_done_i) fire = 1'b1;
        end
        default: state_d = PS_IDLE;
      endcase
    end

    if (fire) begin
      armed_d = 1'b0;
      if (ton_i != '0) begin
        state_d = PS_ON;
        cnt_d   = ton_i;
      end else begin
        go_off  = 1'b1;
      end
    end
    if (go_off) state_d = PS_OFF;

    gate_d = (state_d == PS_ON);
    cnt_we = fire | (state_q == PS_ON);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_IDLE;
      armed_q <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      gate_q  <= gate_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign fire_o  = fire;
  assign off_o   = go_off;
  assign state_o = state_q;
  assign gate_o  = gate_q;

endmodule

// File: rtl/pfc_crm_ctrl.sv
module pfc_crm_ctrl
  import pfc_crm_pkg::*;
#(
  parameter int unsigned ON_W      = 12,
  parameter int unsigned BLANK_CYC = 15,
  parameter int unsigned WDOG_CYC  = 20000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [ON_W-1:0] ton_i,
  input  logic            zcd_i,
  input  logic            ocp_i,
  input  logic            ovp_i,
  output logic            gate_o
);

  logic [FLAG_N-1:0] flag_raw, flag_s;
  logic              zcd_s, ocp_s, ovp_s;
  logic              zcd_rise, zcd_fall;
  logic              blank_done, wd_done;
  logic              fire, go_off;
  pfc_state_e        st;

  always_comb begin
    flag_raw           = '0;
    flag_raw[FLAG_ZCD] = zcd_i;
    flag_raw[FLAG_OCP] = ocp_i;
    flag_raw[FLAG_OVP] = ovp_i;
  end

  pfc_sync2 #(.W(FLAG_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (flag_raw),
    .q_o   (flag_s)
  );

  assign zcd_s = flag_s[FLAG_ZCD];
  assign ocp_s = flag_s[FLAG_OCP];
  assign ovp_s = flag_s[FLAG_OVP];

  pfc_edge u_zcd_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (zcd_s),
    .rise_o(zcd_rise),
    .fall_o(zcd_fall)
  );

  pfc_interval #(.LIMIT(BLANK_CYC)) u_blank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fire),
    .cnt_en_i(st == PS_ON),
    .done_o  (blank_done)
  );

  pfc_interval #(.LIMIT(WDOG_CYC)) u_wdog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (go_off),
    .cnt_en_i(st == PS_OFF),
    .done_o  (wd_done)
  );

  pfc_crm_fsm #(.ON_W(ON_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .ton_i       (ton_i),
    .ovp_s_i     (ovp_s),
    .ocp_s_i     (ocp_s),
    .zcd_rise_i  (zcd_rise),
    .zcd_fall_i  (zcd_fall),
    .blank_done_i(blank_done),
    .wd_done_i   (wd_done),
    .fire_o      (fire),
    .off_o       (go_off),
    .state_o     (st),
    .gate_o      (gate_o)
  );

endmodule

// File: rtl/pfc_crm_chk.sv
module pfc_crm_chk #(
  parameter int unsigned ON_W = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            ovp_s,
  input logic [ON_W-1:0] ton_i,
  input logic            gate_o
);

  logic            g_prev;
  logic [ON_W-1:0] ton_prev, ton_lat;
  logic [ON_W:0]   hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g_prev   <= 1'b0;
      ton_prev <= '0;
      ton_lat  <= '0;
      hi_run   <= '0;
    end else begin
      g_prev   <= gate_o;
      ton_prev <= ton_i;
      if (gate_o && !g_prev) begin
        ton_lat <= ton_prev;
        hi_run  <= (ON_W+1)'(1);
      end else if (gate_o) begin
        hi_run  <= hi_run + 1'b1;
      end else begin
        hi_run  <= '0;
      end
    end
  end

  // R1
  on_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && g_prev) |-> (hi_run < {1'b0, ton_lat}));

  // R2
  zero_ton_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> ($past(ton_i) != '0));

  // R8
  ovp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovp_s |=> !gate_o);

  // R8
  ovp_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> !$past(ovp_s));

  // R9
  en_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !gate_o);

endmodule

bind pfc_crm_ctrl pfc_crm_chk #(.ON_W(ON_W)) u_pfc_crm_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_i  (en_i),
  .ovp_s (ovp_s),
  .ton_i (ton_i),
  .gate_o(gate_o)
);

// File: tb/pfc_crm_ctrl_bench.sv
`timescale 1ns/1ps
module pfc_crm_ctrl_bench;

  localparam int ON_W  = 12;
  localparam int BLANK = 15;
  localparam int WDOG  = 200;
  localparam int NV    = 8;
  localparam int VTON [NV] = '{1, 2, 5, 40, 4095, 40, 10, 300};
  localparam int VOCP [NV] = '{0, 0, 0, 0,  0,    1,  1,  1};
  localparam int VEXP [NV] = '{1, 2, 5, 40, 4095, 15, 10, 15};

  logic            clk = 1'b0;
  logic            rst_n;
  logic            en;
  logic [ON_W-1:0] ton;
  logic            zcd, ocp, ovp;
  logic            gate;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pfc_crm_ctrl #(.ON_W(ON_W), .BLANK_CYC(BLANK), .WDOG_CYC(WDOG)) u_pfc_crm_ctrl (
    .clk_i (clk),
    .rst_ni(rst_n),
    .en_i  (en),
    .ton_i (ton),
    .zcd_i (zcd),
    .ocp_i (ocp),
    .ovp_i (ovp),
    .gate_o(gate)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wait_low();
    for (int i = 0; i < 10000 && gate; i++) @(negedge clk);
  endtask

  // waits for a rise, then counts high samples; acts at count 'at'
  // kind: 0 ton change, 1 ocp glitch, 2 ocp set, 3 ovp set, 4 en clear, 5 none
  task automatic pulse(input int at, input int kind, output int w);
    w = 0;
    for (int i = 0; i < WDOG + 50 && !gate; i++) @(negedge clk);
    while (gate && w < 5000) begin
      w++;
      if (w == at) begin
        case (kind)
          0: ton = 12'd3;
          1: ocp = 1'b1;
          2: ocp = 1'b1;
          3: ovp = 1'b1;
          4: en  = 1'b0;
          default: ;
        endcase
      end
      if (kind == 1 && w == at + 5) ocp = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic count_low(output int w);
    w = 0;
    while (!gate && w < 5000) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic count_high_in(input int cycles, output int h);
    h = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (gate) h++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      report();
      $finish;
    end
  end

  initial begin
    int w, h;
    rst_n = 1'b0; en = 1'b0; ton = 12'd20;
    zcd = 1'b0; ocp = 1'b0; ovp = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 gate low in reset", gate, 0);
    rst_n = 1'b1;
    count_high_in(20, h);
    chk("R9 gate low while disabled", h, 0);

    // R10: forced first turn-on after enable
    en = 1'b1;
    @(negedge clk);
    chk("R10 first turn-on on enable", gate, 1);

    // table walk: R1 widths and R6 blanking with over-current held
    for (int i = 0; i < NV; i++) begin
      wait_low();
      ton = VTON[i][ON_W-1:0];
      ocp = VOCP[i][0];
      pulse(0, 5, w);
      chk(VOCP[i] != 0 ? "R6 held ocp width" : "R1 on-time width", w, VEXP[i]);
      ocp = 1'b0;
    end

    // R1: ton change mid-pulse has no effect
    wait_low(); ton = 12'd50;
    pulse(4, 0, w);
    chk("R1 mid-pulse ton change", w, 50);

    // R6: glitch inside blanking ignored
    wait_low(); ton = 12'd60;
    pulse(2, 1, w);
    chk("R6 ocp in blanking ignored", w, 60);

    // R7: ocp after blanking ends the pulse
    wait_low(); ton = 12'd60;
    pulse(30, 2, w);
    chk("R7 ocp cut width", w, 32);
    ocp = 1'b0;

    // R3: valid zero-crossing restart, third edge after fall
    wait_low(); ton = 12'd20;
    zcd = 1'b1;
    repeat (5) @(negedge clk);
    zcd = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R3 gate before third edge", gate, 0);
    @(negedge clk);
    chk("R3 gate after third edge", gate, 1);

    // R4/R5: rise before turn-on, fall after turn-off is ignored
    wait_low();
    zcd = 1'b1;
    pulse(0, 5, w);
    chk("R1 pulse before ignored fall", w, 20);
    zcd = 1'b0;
    count_low(w);
    chk("R4 unarmed fall ignored", w >= WDOG ? 1 : 0, 1);
    chk("R5 watchdog off-time", w, WDOG);

    // R2: zero on-time gives no pulse
    wait_low(); ton = 12'd0;
    count_high_in(3 * WDOG, h);
    chk("R2 no pulse with zero ton", h, 0);
    ton = 12'd10;
    pulse(0, 5, w);
    chk("R2 pulse resumes", w, 10);

    // R8: over-voltage in off-time holds gate low, release forces on
    wait_low();
    ovp = 1'b1;
    count_high_in(2 * WDOG, h);
    chk("R8 gate held low under ovp", h, 0);
    ovp = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 gate before third edge of release", gate, 0);
    @(negedge clk);
    chk("R8 release pulse", gate, 1);

    // R8: over-voltage during on-time
    wait_low(); ton = 12'd100;
    pulse(10, 3, w);
    chk("R8 ovp cut width", w, 12);
    count_high_in(20, h);
    chk("R8 low while ovp held", h, 0);
    ovp = 1'b0;
    pulse(0, 5, w);
    chk("R8 release pulse width", w, 100);

    // R9/R10: enable drop mid-pulse, then re-enable
    wait_low();
    pulse(5, 4, w);
    chk("R9 en drop width", w, 5);
    count_high_in(3 * WDOG, h);
    chk("R9 low while disabled", h, 0);
    en = 1'b1;
    @(negedge clk);
    chk("R10 restart on re-enable", gate, 1);

    done = 1'b1;
    report();
    $finish;
  end

endmodule